// File: doc/BRIEF.md
# Multi-Window Loss Integration Interlock

This block receives one loss sample per channel at the acquisition rate and keeps four integrals per channel: the latest sample on its own, and three moving sums of increasing length. Each integral is compared on every clock cycle against a threshold held for that channel and that integral. If any integral goes strictly above its threshold, the beam permit output is withdrawn. It stays withdrawn until an operator acknowledge arrives at a moment when every integral is back at or below its limit.

The two longer integrals are built by cascading. Each level stores block sums that the level below hands up at its block boundaries, so no full per-sample history is kept. A level refreshes once per completed block of the level below. All sums saturate at the top of their range. For every channel and integral, the block also records the largest value seen since the last start-of-cycle pulse. A combinational read port returns both the current integral and that maximum for a selected channel and integral. Thresholds are loaded through a single-cycle write port.

Top module: `lossmon_interlock`

## Requirements
- R1: After reset, `permit_o` is 1, every integral and every maximum reads 0, and every threshold holds 2^SUMW-1.
- R2: Integral index 0 equals the most recent sample. Integral index 1 equals the sum of the last LEN1 samples and refreshes with every sample. Samples before reset count as zero.
- R3: Integral index 2 equals the sum of the last LEN2 samples and is refreshed only when the number of samples since reset is a multiple of LEN1. Integral index 3 equals the sum of the last LEN3 samples and is refreshed only when that count is a multiple of LEN2. Between refreshes both hold their value.
- R4: Every integral saturates at 2^SUMW-1 instead of wrapping.
- R5: A write with `thr_we_i` high stores `thr_data_i` as the threshold of channel `thr_ch_i` and integral `thr_win_i`. Integral indices run 0 (shortest) to 3 (longest). No other threshold changes.
- R6: `permit_o` falls at the clock edge that registers a sample raising any integral strictly above its threshold. An integral equal to its threshold does not withdraw the permit.
- R7: A withdrawn permit stays 0, even after all integrals fall back within limits, until `ack_i` is high at an edge where no integral exceeds its threshold. `permit_o` is then 1 after that edge.
- R8: `ack_i` has no effect while any integral exceeds its threshold.
- R9: For each channel and integral, `rd_max_o` returns the largest integral value held since the last `soc_i` pulse. `soc_i` clears all maxima to 0 at its edge.
- R10: Cycles with `sample_valid_i` low leave every integral and phase unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| sample_valid_i | input | 1 | A new sample set is present |
| sample_i | input | NCH*SW | Samples, channel c at bits [c*SW +: SW] |
| soc_i | input | 1 | Start of cycle, clears the maxima |
| ack_i | input | 1 | Operator acknowledge |
| thr_we_i | input | 1 | Threshold write strobe |
| thr_ch_i | input | CHW | Threshold channel index |
| thr_win_i | input | 2 | Threshold integral index |
| thr_data_i | input | SUMW | Threshold value |
| rd_ch_i | input | CHW | Readout channel index |
| rd_win_i | input | 2 | Readout integral index |
| rd_sum_o | output | SUMW | Current integral value |
| rd_max_o | output | SUMW | Maximum since start of cycle |
| permit_o | output | 1 | Beam permit, 1 = beam allowed |

## Verification
The assertions assume every input is a known 0 or 1 once reset is released. They also assume that a permit restored without an acknowledge could only come from reset. The stimulus respects both: it drives every input from a defined value at all times, and it returns the permit only through reset or an acknowledge pulse. Each level's refresh is checked against an arithmetic model of the sample history. Thresholds are swept over every channel and integral, with values that trip on a known sample. The saturation run holds full-scale samples long enough that the longest integral equals but does not exceed the default threshold.

// File: rtl/lossmon_pkg.sv
package lossmon_pkg;
    localparam int unsigned NWIN   = 4;
    localparam int unsigned WSEL_W = 2;

    typedef enum logic [WSEL_W-1:0] {
        WIN_SAMPLE = 2'd0,
        WIN_SHORT  = 2'd1,
        WIN_MEDIUM = 2'd2,
        WIN_CYCLE  = 2'd3
    } win_sel_e;
endpackage

// File: rtl/lossmon_window.sv
// One cascade level: a shift ring of block sums, summed with saturation.
module lossmon_window #(
    parameter int unsigned SUMW  = 16,
    parameter int unsigned DEPTH = 4
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            push_i,
    input  logic [SUMW-1:0] chunk_i,
    output logic [SUMW-1:0] sum_o,
    output logic [SUMW-1:0] next_o
);
    localparam int unsigned ACCW = SUMW + $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][SUMW-1:0] ring;
        logic [SUMW-1:0]            sum;
    } win_st_t;

    win_st_t         st_d, st_q;
    logic [ACCW-1:0] acc;

    always_comb begin
        st_d = st_q;
        if (push_i) begin
            for (int d = 1; d < DEPTH; d++) begin
                st_d.ring[d] = st_q.ring[d-1];
            end
            st_d.ring[0] = chunk_i;
        end
        acc = '0;
        for (int d = 0; d < DEPTH; d++) begin
            acc = acc + ACCW'(st_d.ring[d]);
        end
        st_d.sum = (acc[ACCW-1:SUMW] != '0) ? '1 : acc[SUMW-1:0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign sum_o  = st_q.sum;
    assign next_o = st_d.sum;
endmodule

// File: rtl/lossmon_thr_regs.sv
module lossmon_thr_regs #(
    parameter int unsigned NCH  = 8,
    parameter int unsigned NWIN = 4,
    parameter int unsigned SUMW = 16,
    parameter int unsigned CHW  = 3,
    parameter int unsigned WSW  = 2
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            we_i,
    input  logic [CHW-1:0]  ch_i,
    input  logic [WSW-1:0]  win_i,
    input  logic [SUMW-1:0] data_i,
    output logic [SUMW-1:0] thr_o [NCH][NWIN]
);
    typedef struct packed {
        logic [NCH-1:0][NWIN-1:0][SUMW-1:0] thr;
    } thr_st_t;

    thr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i && ({1'b0, ch_i} < (CHW+1)'(NCH)) && ({1'b0, win_i} < (WSW+1)'(NWIN))) begin
            st_d.thr[ch_i][win_i] = data_i;
        end
        for (int c = 0; c < NCH; c++) begin
            for (int k = 0; k < NWIN; k++) begin
                thr_o[c][k] = st_q.thr[c][k];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '1;
        else         st_q <= st_d;
    end
endmodule

// File: rtl/lossmon_peak.sv
module lossmon_peak #(
    parameter int unsigned NCH  = 8,
    parameter int unsigned NWIN = 4,
    parameter int unsigned SUMW = 16
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            soc_i,
    input  logic [SUMW-1:0] win_i  [NCH][NWIN],
    output logic [SUMW-1:0] peak_o [NCH][NWIN]
);
    typedef struct packed {
        logic [NCH-1:0][NWIN-1:0][SUMW-1:0] pk;
    } peak_st_t;

    peak_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int c = 0; c < NCH; c++) begin
            for (int k = 0; k < NWIN; k++) begin
                if (soc_i)                       st_d.pk[c][k] = '0;
                else if (win_i[c][k] > st_q.pk[c][k]) st_d.pk[c][k] = win_i[c][k];
                peak_o[c][k] = st_q.pk[c][k];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end
endmodule

// File: rtl/lossmon_interlock.sv
module lossmon_interlock
    import lossmon_pkg::*;
#(
    parameter  int unsigned NCH  = 8,
    parameter  int unsigned SW   = 12,
    parameter  int unsigned SUMW = 16,
    parameter  int unsigned LEN1 = 4,
    parameter  int unsigned LEN2 = 16,
    parameter  int unsigned LEN3 = 64,
    localparam int unsigned CHW  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                sample_valid_i,
    input  logic [NCH*SW-1:0]   sample_i,
    input  logic                soc_i,
    input  logic                ack_i,
    input  logic                thr_we_i,
    input  logic [CHW-1:0]      thr_ch_i,
    input  logic [WSEL_W-1:0]   thr_win_i,
    input  logic [SUMW-1:0]     thr_data_i,
    input  logic [CHW-1:0]      rd_ch_i,
    input  logic [WSEL_W-1:0]   rd_win_i,
    output logic [SUMW-1:0]     rd_sum_o,
    output logic [SUMW-1:0]     rd_max_o,
    output logic                permit_o
);
    // Blocks per level; level k spans DEP[1]*...*DEP[k] samples.
    localparam int unsigned DEP [NWIN] = '{1, LEN1, LEN2 / LEN1, LEN3 / LEN2};
    localparam int unsigned PHW = $clog2(LEN3 + 1);

    typedef struct packed {
        logic [NWIN-1:0][PHW-1:0] phase;
        logic                     permit;
    } top_st_t;

    top_st_t         st_d, st_q;
    logic [NWIN-1:0] push;
    logic            trip;
    logic [SUMW-1:0] win  [NCH][NWIN];
    logic [SUMW-1:0] nxt  [NCH][NWIN];
    logic [SUMW-1:0] thr  [NCH][NWIN];
    logic [SUMW-1:0] peak [NCH][NWIN];

    // A level accepts a block when the level below completes one.
    always_comb begin
        push[0] = sample_valid_i;
        for (int k = 1; k < NWIN; k++) begin
            push[k] = push[k-1] && (st_q.phase[k-1] == PHW'(DEP[k-1] - 1));
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        for (genvar k = 0; k < NWIN; k++) begin : g_lvl
            logic [SUMW-1:0] chunk;
            if (k == 0) begin : g_head
                assign chunk = SUMW'(sample_i[c*SW +: SW]);
            end else begin : g_tail
                assign chunk = nxt[c][k-1];
            end
            lossmon_window #(.SUMW(SUMW), .DEPTH(DEP[k])) u_win (
                .clk_i   (clk_i),
                .rst_ni  (rst_ni),
                .push_i  (push[k]),
                .chunk_i (chunk),
                .sum_o   (win[c][k]),
                .next_o  (nxt[c][k])
            );
        end
    end

    lossmon_thr_regs #(.NCH(NCH), .NWIN(NWIN), .SUMW(SUMW), .CHW(CHW), .WSW(WSEL_W)) u_thr (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .we_i   (thr_we_i),
        .ch_i   (thr_ch_i),
        .win_i  (thr_win_i),
        .data_i (thr_data_i),
        .thr_o  (thr)
    );

    lossmon_peak #(.NCH(NCH), .NWIN(NWIN), .SUMW(SUMW)) u_peak (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .soc_i  (soc_i),
        .win_i  (win),
        .peak_o (peak)
    );

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < NWIN; k++) begin
            if (push[k]) begin
                st_d.phase[k] = (st_q.phase[k] == PHW'(DEP[k] - 1)) ? '0 : st_q.phase[k] + 1'b1;
            end
        end
        trip = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            for (int k = 0; k < NWIN; k++) begin
                if (nxt[c][k] > thr[c][k]) trip = 1'b1;
            end
        end
        if (trip)       st_d.permit = 1'b0;
        else if (ack_i) st_d.permit = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q        <= '0;
            st_q.permit <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_sum_o = '0;
        rd_max_o = '0;
        if ({1'b0, rd_ch_i} < (CHW+1)'(NCH)) begin
            rd_sum_o = win[rd_ch_i][rd_win_i];
            rd_max_o = peak[rd_ch_i][rd_win_i];
        end
    end

    assign permit_o = st_q.permit;
endmodule

// File: rtl/lossmon_interlock_chk.sv
module lossmon_interlock_chk #(
    parameter int unsigned SUMW = 16
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            ack_i,
    input logic            soc_i,
    input logic            permit_i,
    input logic            trip_i,
    input logic [SUMW-1:0] rd_max_i
);
    assert_trip_drops_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trip_i |=> !permit_i);

    assert_fall_has_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(permit_i) |-> $past(trip_i));

    assert_rise_needs_ack_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(permit_i) |-> $past(ack_i));

    assert_ack_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(permit_i) |-> !$past(trip_i));

    assert_soc_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        soc_i |=> (rd_max_i == '0));
endmodule

bind lossmon_interlock lossmon_interlock_chk #(.SUMW(SUMW)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ack_i    (ack_i),
    .soc_i    (soc_i),
    .permit_i (permit_o),
    .trip_i   (trip),
    .rd_max_i (rd_max_o)
);

// File: tb/tb_lossmon_interlock.sv
`timescale 1ns/1ps
module tb_lossmon_interlock;
    localparam int NCH = 8, SW = 12, SUMW = 16, LEN1 = 4, LEN2 = 16, LEN3 = 64, CHW = 3;
    localparam int SATV = 65535;

    logic clk = 1'b0, rst_n = 1'b0, valid = 1'b0, soc = 1'b0, ack = 1'b0, we = 1'b0;
    logic [NCH*SW-1:0] samp = '0;
    logic [CHW-1:0] thr_ch = '0, rd_ch = '0;
    logic [1:0] thr_win = '0, rd_win = '0;
    logic [SUMW-1:0] thr_data = '0, rd_sum, rd_max;
    logic permit;

    always #2 clk = ~clk;

    lossmon_interlock #(.NCH(NCH), .SW(SW), .SUMW(SUMW), .LEN1(LEN1), .LEN2(LEN2), .LEN3(LEN3)) dut (
        .clk_i(clk), .rst_ni(rst_n), .sample_valid_i(valid), .sample_i(samp), .soc_i(soc),
        .ack_i(ack), .thr_we_i(we), .thr_ch_i(thr_ch), .thr_win_i(thr_win), .thr_data_i(thr_data),
        .rd_ch_i(rd_ch), .rd_win_i(rd_win), .rd_sum_o(rd_sum), .rd_max_o(rd_max), .permit_o(permit));

    int checks = 0, errors = 0;
    bit done = 1'b0;
    int hist [NCH][LEN3];
    int mw [NCH][4], mmax [NCH][4], mthr [NCH][4];
    int n, mperm;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int hsum(input int c, input int len);
        int s = 0;
        for (int i = 0; i < len; i++) s += hist[c][i];
        return (s > SATV) ? SATV : s;
    endfunction

    function automatic bit mtrip();
        for (int c = 0; c < NCH; c++)
            for (int k = 0; k < 4; k++)
                if (mw[c][k] > mthr[c][k]) return 1'b1;
        return 1'b0;
    endfunction

    task automatic model_reset();
        n = 0; mperm = 1;
        for (int c = 0; c < NCH; c++) begin
            for (int i = 0; i < LEN3; i++) hist[c][i] = 0;
            for (int k = 0; k < 4; k++) begin mw[c][k] = 0; mmax[c][k] = 0; mthr[c][k] = SATV; end
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; valid = 1'b0; soc = 1'b0; ack = 1'b0; we = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        model_reset();
    endtask

    // One sample, then one idle edge so maxima and permit settle.
    task automatic push(input int v [NCH], input int idle);
        @(negedge clk);
        for (int c = 0; c < NCH; c++) samp[c*SW +: SW] = SW'(v[c]);
        valid = 1'b1;
        @(negedge clk); valid = 1'b0;
        n++;
        for (int c = 0; c < NCH; c++) begin
            for (int i = LEN3-1; i > 0; i--) hist[c][i] = hist[c][i-1];
            hist[c][0] = v[c];
            mw[c][0] = v[c];
            mw[c][1] = hsum(c, LEN1);
            if (n % LEN1 == 0) mw[c][2] = hsum(c, LEN2);
            if (n % LEN2 == 0) mw[c][3] = hsum(c, LEN3);
        end
        if (mtrip()) mperm = 0;
        repeat (1 + idle) @(negedge clk);
        for (int c = 0; c < NCH; c++)
            for (int k = 0; k < 4; k++)
                if (mw[c][k] > mmax[c][k]) mmax[c][k] = mw[c][k];
    endtask

    task automatic check_all(input string extra);
        for (int c = 0; c < NCH; c++) begin
            for (int k = 0; k < 4; k++) begin
                @(negedge clk); rd_ch = CHW'(c); rd_win = 2'(k); #1;
                check(rd_sum == SUMW'(mw[c][k]), (k < 2) ? {"R2", extra} : {"R3", extra},
                      int'(rd_sum), mw[c][k]);
                check(rd_max == SUMW'(mmax[c][k]), "R9", int'(rd_max), mmax[c][k]);
            end
        end
    endtask

    task automatic check_permit(input string req);
        #1 check(permit == mperm[0], req, int'(permit), mperm);
    endtask

    task automatic write_thr(input int c, input int k, input int val);
        @(negedge clk); we = 1'b1; thr_ch = CHW'(c); thr_win = 2'(k); thr_data = SUMW'(val);
        @(negedge clk); we = 1'b0;
        mthr[c][k] = val;
    endtask

    task automatic pulse_ack();
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
        if (!mtrip()) mperm = 1;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int v [NCH];
        int tv [4];
        tv = '{9, 25, 70, 150};
        do_reset();
        // R1: reset state
        check_permit("R1");
        check_all("_R1");

        // R2 R3 R10: varied patterns, idle gaps every fifth sample
        for (int s = 0; s < 80; s++) begin
            for (int c = 0; c < NCH; c++) v[c] = (c * 523 + s * 97 + s * s * 7) % 4096;
            push(v, (s % 5 == 4) ? 3 : 0);
            if (s % 5 == 4) check_all("_R10");
            else if (s % 3 == 0) check_all("");
        end
        check_permit("R6");

        // R9: start of cycle clears maxima, then tracking restarts
        @(negedge clk); soc = 1'b1; rd_ch = 3'd3; rd_win = 2'd2;
        @(negedge clk); soc = 1'b0; #1;
        check(rd_max == '0, "R9", int'(rd_max), 0);
        for (int c = 0; c < NCH; c++) for (int k = 0; k < 4; k++) mmax[c][k] = mw[c][k];
        for (int s = 0; s < 10; s++) begin
            for (int c = 0; c < NCH; c++) v[c] = (c * 11 + s * 3) % 50;
            push(v, 0);
        end
        check_all("_R9");

        // R4: full-scale samples saturate the longest integral; equal to threshold keeps permit
        do_reset();
        for (int c = 0; c < NCH; c++) v[c] = 4095;
        for (int s = 0; s < LEN3; s++) push(v, 0);
        for (int c = 0; c < NCH; c++) begin
            @(negedge clk); rd_ch = CHW'(c); rd_win = 2'd3; #1;
            check(rd_sum == SUMW'(SATV), "R4", int'(rd_sum), SATV);
        end
        check_all("_R4");
        check_permit("R6");

        // R5 R6 R7 R8: every channel and integral trips on its own threshold
        for (int c = 0; c < NCH; c++) begin
            for (int k = 0; k < 4; k++) begin
                do_reset();
                write_thr(c, k, tv[k]);
                check_permit("R5");
                for (int s = 0; s < 20; s++) begin
                    for (int cc = 0; cc < NCH; cc++) v[cc] = (cc == c) ? 10 : 4095;
                    push(v, 0);
                    check_permit("R6");
                end
                pulse_ack();
                check_permit("R8");
                write_thr(c, k, SATV);
                repeat (2) @(negedge clk);
                check_permit("R7");
                pulse_ack();
                check_permit("R7");
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule